// File: doc/BRIEF.md
# Per-Flow Center-Stage Spreader

This block sits at an input switching element (SE) of a three-stage Clos packet switch and decides which center SE each arriving cell will cross. The caller classifies every cell into a flow, meaning the cells that share a source and a destination, and presents the flow ID with a one-cycle arrival strobe. The block keeps a separate rotating counter for every flow. The cell is tagged with the counter's current value, and the counter then moves one step around the ring of `CENTERS` center SEs. Consecutive cells of a flow are therefore spread evenly over the middle stage.

The SEs of the switch are aligned only at frame boundaries. On the frame-start pulse every flow counter is reloaded with a staggered start point: the sum of this SE's own index and the flow index, taken modulo the number of center SEs. Because of this offset, different flows, and the same flow at different input SEs, begin each frame on different center SEs. This avoids the case where every flow opens the frame on center SE 0.

The tag is registered and is presented one cycle after the strobe, together with the flow ID it belongs to. The stepping direction is chosen at build time.

Top module: `lbs_spreader`

## Requirements
- R1: Every tag delivered on `tag_center` lies in the range 0 to `CENTERS`-1.
- R2: A cell is tagged with its flow's current counter value. The counter then steps once around the ring: with `STEP_UP`=1 it goes from v to v+1 and wraps from `CENTERS`-1 to 0; with `STEP_UP`=0 it goes from v to v-1 and wraps from 0 to `CENTERS`-1.
- R3: On a `frame_start` pulse the counter of every flow g is loaded with (`se_index` + g) mod `CENTERS`.
- R4: A cell of one flow leaves the counters of all other flows unchanged.
- R5: When a cell arrives in the same cycle as `frame_start`, the cell takes its flow's freshly loaded start value and the counter steps from that value.
- R6: `tag_valid` is high exactly one cycle after each cycle with `cell_valid` high, and in that cycle `tag_flow` repeats the flow ID of the cell. `tag_valid` is low in every other cycle.
- R7: After reset `tag_valid` is low and every flow counter holds 0 until the first frame start.
- R8: A `se_index` value of `CENTERS` or more enters the start-value formula unchanged, so the start value is still (`se_index` + g) mod `CENTERS`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cell_valid | input | 1 | One cell arrives this cycle |
| cell_flow | input | FW | Flow ID of the arriving cell |
| frame_start | input | 1 | Frame boundary: reload all counters |
| se_index | input | SEW | Index of this input SE (configuration) |
| tag_valid | output | 1 | Tag output valid |
| tag_flow | output | FW | Flow ID belonging to the tag |
| tag_center | output | CW | Center SE assigned to the cell |

## Verification
The bench builds two instances and drives both with the same stimulus. The first has 8 flows, 5 center SEs and incrementing counters. The ring size of 5 is not a power of two, so a wrap that relies on bit truncation would be caught. The second has 8 flows, 4 center SEs and decrementing counters, which exercises the wrap from 0 back to the top of the ring. A `se_index` width of 4 bits allows values above the ring size, so the modulo reduction of the SE index is exercised. It also lets the start offsets sweep all positions while frame pulses collide at random with cell arrivals.

// File: rtl/lbs_pkg.sv
package lbs_pkg;

  // Next ring position: one step up or down with wrap-around.
  function automatic int unsigned lbs_ring_step(int unsigned cur, int unsigned ring, bit up);
    if (up) return (cur >= ring - 1) ? 0 : cur + 1;
    else    return (cur == 0) ? ring - 1 : cur - 1;
  endfunction

  // Staggered start point for a flow: (se + flow) mod ring.
  function automatic int unsigned lbs_start_point(int unsigned se, int unsigned flow, int unsigned ring);
    int unsigned s;
    s = (se % ring) + (flow % ring);
    if (s >= ring) s = s - ring;
    return s;
  endfunction

endpackage

// File: rtl/lbs_seed_gen.sv
module lbs_seed_gen #(
  parameter int FLOWS   = 8,
  parameter int CENTERS = 5,
  parameter int SEW     = 4,
  localparam int CW     = (CENTERS > 1) ? $clog2(CENTERS) : 1
) (
  input  logic [SEW-1:0]            se_index,
  output logic [FLOWS-1:0][CW-1:0]  seed
);
  import lbs_pkg::*;

  for (genvar g = 0; g < FLOWS; g++) begin : g_seed
    always_comb seed[g] = CW'(lbs_start_point(int'(se_index), g, CENTERS));
  end

endmodule

// File: rtl/lbs_flow_ctr.sv
module lbs_flow_ctr #(
  parameter int CENTERS = 5,
  parameter bit STEP_UP = 1'b1,
  localparam int CW     = (CENTERS > 1) ? $clog2(CENTERS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic          hit,
  input  logic [CW-1:0] seed,
  output logic [CW-1:0] use_val,
  output logic [CW-1:0] cnt
);
  import lbs_pkg::*;

  logic [CW-1:0] stepped;

  // Frame reload takes effect before the arriving cell reads the counter.
  always_comb begin
    use_val = frame_start ? seed : cnt;
    stepped = CW'(lbs_ring_step(int'(use_val), CENTERS, STEP_UP));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (hit)         cnt <= stepped;
    else if (frame_start) cnt <= seed;
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) < CENTERS);  // R1
  AST_STEP_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !frame_start) |=> int'(cnt) == lbs_ring_step(int'($past(cnt)), CENTERS, STEP_UP));  // R2
  AST_FRAME_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !hit) |=> cnt == $past(seed));  // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !frame_start) |=> $stable(cnt));  // R4
  AST_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && hit) |=> int'(cnt) == lbs_ring_step(int'($past(seed)), CENTERS, STEP_UP));  // R5

endmodule

// File: rtl/lbs_tag_stage.sv
module lbs_tag_stage #(
  parameter int FLOWS   = 8,
  parameter int CENTERS = 5,
  localparam int FW     = (FLOWS > 1) ? $clog2(FLOWS) : 1,
  localparam int CW     = (CENTERS > 1) ? $clog2(CENTERS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cell_valid,
  input  logic [FW-1:0]             cell_flow,
  input  logic [FLOWS-1:0][CW-1:0]  use_vals,
  output logic                      tag_valid,
  output logic [FW-1:0]             tag_flow,
  output logic [CW-1:0]             tag_center
);

  logic [CW-1:0] picked;

  always_comb begin
    picked = '0;
    for (int g = 0; g < FLOWS; g++)
      if (cell_flow == FW'(g)) picked = use_vals[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_valid  <= 1'b0;
      tag_flow   <= '0;
      tag_center <= '0;
    end else begin
      tag_valid <= cell_valid;
      if (cell_valid) begin
        tag_flow   <= cell_flow;
        tag_center <= picked;
      end
    end
  end

  AST_TAG_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    cell_valid |=> tag_valid && tag_flow == $past(cell_flow));  // R6
  AST_TAG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cell_valid |=> !tag_valid);  // R6
  AST_TAG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    tag_valid |-> int'(tag_center) < CENTERS);  // R1

endmodule

// File: rtl/lbs_spreader.sv
module lbs_spreader #(
  parameter int FLOWS   = 8,
  parameter int CENTERS = 5,
  parameter int SEW     = 4,
  parameter bit STEP_UP = 1'b1,
  localparam int FW     = (FLOWS > 1) ? $clog2(FLOWS) : 1,
  localparam int CW     = (CENTERS > 1) ? $clog2(CENTERS) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cell_valid,
  input  logic [FW-1:0]  cell_flow,
  input  logic           frame_start,
  input  logic [SEW-1:0] se_index,
  output logic           tag_valid,
  output logic [FW-1:0]  tag_flow,
  output logic [CW-1:0]  tag_center
);

  logic [FLOWS-1:0][CW-1:0] seed;
  logic [FLOWS-1:0][CW-1:0] use_vals;
  logic [FLOWS-1:0][CW-1:0] counts;
  logic [FLOWS-1:0]         flow_hit;

  lbs_seed_gen #(.FLOWS(FLOWS), .CENTERS(CENTERS), .SEW(SEW)) u_seed (
    .se_index (se_index),
    .seed     (seed)
  );

  for (genvar g = 0; g < FLOWS; g++) begin : g_flow
    assign flow_hit[g] = cell_valid && (cell_flow == FW'(g));

    lbs_flow_ctr #(.CENTERS(CENTERS), .STEP_UP(STEP_UP)) u_ctr (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (frame_start),
      .hit         (flow_hit[g]),
      .seed        (seed[g]),
      .use_val     (use_vals[g]),
      .cnt         (counts[g])
    );
  end

  lbs_tag_stage #(.FLOWS(FLOWS), .CENTERS(CENTERS)) u_tag (
    .clk        (clk),
    .rst_n      (rst_n),
    .cell_valid (cell_valid),
    .cell_flow  (cell_flow),
    .use_vals   (use_vals),
    .tag_valid  (tag_valid),
    .tag_flow   (tag_flow),
    .tag_center (tag_center)
  );

  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flow_hit));  // R4
  AST_HIT_WHEN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    cell_valid |-> $countones(flow_hit) == 1 || int'(cell_flow) >= FLOWS);  // R4

endmodule

// File: tb/lbs_spreader_tb.sv
module lbs_spreader_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NF  = 8;
  localparam int LU  = 5;
  localparam int LD  = 4;
  localparam int SEW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cell_valid = 1'b0;
  logic [2:0] cell_flow = '0;
  logic frame_start = 1'b0;
  logic [SEW-1:0] se_index = '0;

  logic tv_u, tv_d;
  logic [2:0] tf_u, tf_d;
  logic [2:0] tc_u;
  logic [1:0] tc_d;

  int checks = 0;
  int fails  = 0;
  int cnt_u [NF];
  int cnt_d [NF];

  always #(CLK_PERIOD/2) clk = ~clk;

  lbs_spreader #(.FLOWS(NF), .CENTERS(LU), .SEW(SEW), .STEP_UP(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .cell_valid(cell_valid), .cell_flow(cell_flow),
    .frame_start(frame_start), .se_index(se_index),
    .tag_valid(tv_u), .tag_flow(tf_u), .tag_center(tc_u));

  lbs_spreader #(.FLOWS(NF), .CENTERS(LD), .SEW(SEW), .STEP_UP(1'b0)) u_dut_dn (
    .clk(clk), .rst_n(rst_n), .cell_valid(cell_valid), .cell_flow(cell_flow),
    .frame_start(frame_start), .se_index(se_index),
    .tag_valid(tv_d), .tag_flow(tf_d), .tag_center(tc_d));

  // Bench's own restatement of the ring arithmetic.
  function automatic int nxt(int v, int ring, bit up);
    return up ? (v + 1) % ring : (v + ring - 1) % ring;
  endfunction

  function automatic int start_of(int se, int g, int ring);
    return (se + g) % ring;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, clock in, check at following negedge.
  task automatic cyc(bit v, int f, bit fs, string req);
    int eu, ed;
    cell_valid  = v;
    cell_flow   = 3'(f);
    frame_start = fs;
    eu = fs ? start_of(int'(se_index), f, LU) : cnt_u[f];
    ed = fs ? start_of(int'(se_index), f, LD) : cnt_d[f];
    if (fs)
      for (int g = 0; g < NF; g++) begin
        cnt_u[g] = start_of(int'(se_index), g, LU);
        cnt_d[g] = start_of(int'(se_index), g, LD);
      end
    if (v) begin
      cnt_u[f] = nxt(eu, LU, 1'b1);
      cnt_d[f] = nxt(ed, LD, 1'b0);
    end
    @(negedge clk);
    chk(tv_u == v, "R6", int'(tv_u), int'(v));
    chk(tv_d == v, "R6", int'(tv_d), int'(v));
    if (v) begin
      chk(int'(tf_u) == f, "R6", int'(tf_u), f);
      chk(int'(tc_u) == eu, req, int'(tc_u), eu);
      chk(int'(tc_d) == ed, req, int'(tc_d), ed);
      chk(int'(tc_u) < LU && int'(tc_d) < LD, "R1", int'(tc_u), eu);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int g = 0; g < NF; g++) begin cnt_u[g] = 0; cnt_d[g] = 0; end
    repeat (3) @(negedge clk);
    chk(tv_u == 1'b0 && tv_d == 1'b0, "R7", int'(tv_u), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R7: counters start at zero; R2: wrap in both directions
    cyc(1'b1, 0, 1'b0, "R7");
    for (int k = 0; k < 6; k++) cyc(1'b1, 0, 1'b0, "R2");
    cyc(1'b0, 0, 1'b0, "R6");
    // R3: frame reload with se_index 2
    se_index = 4'd2;
    cyc(1'b0, 0, 1'b1, "R3");
    cyc(1'b1, 3, 1'b0, "R3");
    // R4: other flows untouched
    for (int k = 0; k < 3; k++) cyc(1'b1, 1, 1'b0, "R2");
    cyc(1'b1, 6, 1'b0, "R4");
    // R5: collision of frame pulse and arrival
    cyc(1'b1, 4, 1'b1, "R5");
    cyc(1'b1, 4, 1'b0, "R5");
    // R8: se_index above ring size
    se_index = 4'd7;
    cyc(1'b0, 0, 1'b1, "R8");
    cyc(1'b1, 0, 1'b0, "R8");
    cyc(1'b1, 7, 1'b0, "R8");
    se_index = 4'd15;
    cyc(1'b1, 5, 1'b1, "R8");
    // Random mix
    for (int k = 0; k < 2000; k++) begin
      if ($urandom_range(0, 30) == 0) se_index = 4'($urandom_range(0, 15));
      cyc($urandom_range(0, 9) < 7, $urandom_range(0, NF-1),
          $urandom_range(0, 19) == 0, "R2");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule